// File: doc/BRIEF.md
# Multi-Valued-Logic Scan Stimulus Receiver with Signature-Checked Retest

This block sits on the device side of a test channel that delivers five scan-test stimulus bits per clock as one 32-level symbol. A converter outside the block turns the analog level into a 5-bit code. The block registers that code and splits it into three primary test inputs, a scan-in bit and a scan-enable bit, each driven to the logic under test. Clock and reset are not carried by the symbol. They stay ordinary binary inputs.

A level that the channel delivers wrongly would corrupt the stimulus without any sign at the point of arrival. To catch this, every received symbol is folded into a 16-bit multiple-input signature register. When the tester marks the end of a test pass, the block compares the signature with an expected value that the tester supplies. A match gives a pass verdict. A mismatch means the channel corrupted at least one symbol, and the block asks for the whole test to be applied again. It does this only a limited number of times per device: after the fourth corrupted application it reports failure instead. A new-device pulse restarts the attempt count.

Top module: `mvl_test_rx`

## Requirements
- R1: While reset is low and in the first cycle after it is released, test_pi, scan_in, scan_en, test_valid, pass, fail and retest are all 0.
- R2: One cycle after a cycle with sym_valid high, the outputs take the symbol fields as follows: test_pi[0], test_pi[1] and test_pi[2] come from sym_in bits 0, 1 and 2, scan_in comes from bit 3, and scan_en comes from bit 4. These outputs hold their value through cycles with sym_valid low.
- R3: test_valid equals sym_valid delayed by exactly one cycle.
- R4: The signature is 16 bits wide and starts at zero. On each valid symbol it becomes (s<<1) XOR (0x1021 if s[15] was 1) XOR the symbol placed in bits 4..0. A pass_end or a dev_start clears it. A symbol valid in that same cycle is folded into the cleared value, so it belongs to the next pass.
- R5: One cycle after pass_end, pass pulses for one cycle if the signature formed from earlier symbols equals exp_sig.
- R6: On a mismatch, retest pulses for one cycle one cycle after pass_end, but only when the attempt count including this pass is below 4.
- R7: On a mismatch at the fourth or a later attempt, fail pulses for one cycle one cycle after pass_end, and retest stays low.
- R8: At most one of pass, fail and retest is high in any cycle. Outside the cycle after a pass_end, all three are low.
- R9: The attempt count goes up by one on each pass_end and stops at 4. dev_start resets it to zero. When dev_start and pass_end come in the same cycle, dev_start wins and no verdict is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Binary test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_start | input | 1 | Pulse at the start of a new device; clears attempts and signature |
| sym_valid | input | 1 | sym_in holds a decoded symbol this cycle |
| sym_in | input | 5 | Decoded 32-level symbol |
| pass_end | input | 1 | End-of-pass strobe; triggers the signature comparison |
| exp_sig | input | 16 | Expected signature, sampled with pass_end |
| test_pi | output | 3 | Unpacked primary test inputs |
| scan_in | output | 1 | Unpacked scan data bit |
| scan_en | output | 1 | Unpacked scan enable |
| test_valid | output | 1 | Unpacked fields were updated this cycle |
| pass | output | 1 | Verdict pulse: signature matched |
| fail | output | 1 | Verdict pulse: mismatch with attempts used up |
| retest | output | 1 | Verdict pulse: mismatch, apply the test again |

## Verification
Every result of this block comes from exactly one register stage. The unpacked fields and test_valid follow a symbol one cycle later. A verdict follows its pass_end one cycle later and is based on the signature as it stood before that edge. The driver changes inputs on the falling edge and queues the outputs the model expects after the next rising edge. The monitor waits 2 ns past each rising edge and pops exactly one entry, so each comparison lands in the single cycle in which its result is due. The bench model works out the signature and the attempt count from the requirement formulas, and it builds both matching and deliberately wrong expected signatures from that model.

// File: rtl/mvl_rx_pkg.sv
package mvl_rx_pkg;
   localparam int SYM_W = 5;
   localparam int PI_W  = 3;

   // Field order of a decoded symbol, most significant field first.
   typedef struct packed {
      logic            scan_en;
      logic            scan_in;
      logic [PI_W-1:0] pi;
   } scan_vec_t;

   typedef enum logic [1:0] {
      VRD_NONE   = 2'd0,
      VRD_PASS   = 2'd1,
      VRD_RETEST = 2'd2,
      VRD_FAIL   = 2'd3
   } verdict_e;
endpackage

// File: rtl/mvl_sym_unpack.sv
module mvl_sym_unpack
   import mvl_rx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_valid,
   input  logic [SYM_W-1:0] sym_in,
   output scan_vec_t        fields,
   output logic             fields_valid
);
   scan_vec_t sym_cast;
   assign sym_cast = scan_vec_t'(sym_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fields       <= '0;
         fields_valid <= 1'b0;
      end else begin
         fields_valid <= sym_valid;
         if (sym_valid) fields <= sym_cast;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid |=> fields_valid); // R3
   AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_valid |=> $stable(fields)); // R2
endmodule

// File: rtl/mvl_misr.sv
module mvl_misr #(
   parameter int              SIG_W = 16,
   parameter int              IN_W  = 5,
   parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             fold,
   input  logic [IN_W-1:0]  din,
   output logic [SIG_W-1:0] sig
);
   localparam int TOP = SIG_W - 1;

   if (IN_W > SIG_W) begin : g_bad_width
      $error("mvl_misr: input wider than signature");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("mvl_misr: polynomial needs a constant term");
   end

   logic [SIG_W-1:0] base;
   logic [SIG_W-1:0] nxt;
   logic             fb;

   assign base = clear ? '0 : sig;
   assign fb   = base[TOP];

   for (genvar i = 0; i < SIG_W; i++) begin : g_bit
      logic shifted;
      logic injected;
      if (i == 0) begin : g_lsb
         assign shifted = 1'b0;
      end else begin : g_mid
         assign shifted = base[i-1];
      end
      if (i < IN_W) begin : g_in
         assign injected = fold & din[i];
      end else begin : g_noin
         assign injected = 1'b0;
      end
      assign nxt[i] = shifted ^ (fb & POLY[i]) ^ injected;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sig <= '0;
      else if (clear || fold) sig <= nxt;
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !fold) |=> (sig == '0)); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !fold) |=> $stable(sig)); // R4
endmodule

// File: rtl/mvl_retry_ctrl.sv
module mvl_retry_ctrl
   import mvl_rx_pkg::*;
#(
   parameter int MAX_TRIES = 4,
   parameter int CNT_W     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dev_start,
   input  logic pass_end,
   input  logic sig_ok,
   output logic pass,
   output logic fail,
   output logic retest
);
   if (MAX_TRIES < 1 || MAX_TRIES >= (1 << CNT_W)) begin : g_bad_cnt
      $error("mvl_retry_ctrl: attempt limit does not fit the counter");
   end

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_TRIES);

   logic [CNT_W-1:0] tries;
   logic [CNT_W-1:0] tries_nxt;
   verdict_e         vrd;
   verdict_e         vrd_nxt;

   assign tries_nxt = (tries == LIMIT) ? LIMIT : tries + 1'b1;

   always_comb begin
      vrd_nxt = VRD_NONE;
      if (pass_end && !dev_start) begin
         if (sig_ok)                vrd_nxt = VRD_PASS;
         else if (tries_nxt < LIMIT) vrd_nxt = VRD_RETEST;
         else                       vrd_nxt = VRD_FAIL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tries <= '0;
         vrd   <= VRD_NONE;
      end else begin
         vrd <= vrd_nxt;
         if (dev_start)     tries <= '0;
         else if (pass_end) tries <= tries_nxt;
      end
   end

   assign pass   = (vrd == VRD_PASS);
   assign retest = (vrd == VRD_RETEST);
   assign fail   = (vrd == VRD_FAIL);

   AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tries <= LIMIT); // R9
   AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (tries == LIMIT)); // R7
   AST_RETEST_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      retest |-> (tries < LIMIT)); // R6
   AST_DEV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      dev_start |=> (tries == '0) && !pass && !fail && !retest); // R9
endmodule

// File: rtl/mvl_test_rx.sv
module mvl_test_rx
   import mvl_rx_pkg::*;
#(
   parameter int               SIG_W     = 16,
   parameter logic [SIG_W-1:0] POLY      = 16'h1021,
   parameter int               MAX_TRIES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dev_start,
   input  logic             sym_valid,
   input  logic [SYM_W-1:0] sym_in,
   input  logic             pass_end,
   input  logic [SIG_W-1:0] exp_sig,
   output logic [PI_W-1:0]  test_pi,
   output logic             scan_in,
   output logic             scan_en,
   output logic             test_valid,
   output logic             pass,
   output logic             fail,
   output logic             retest
);
   localparam int CNT_W = $clog2(MAX_TRIES + 1);

   if (SIG_W < SYM_W) begin : g_bad_sig
      $error("mvl_test_rx: signature narrower than a symbol");
   end

   scan_vec_t        fields;
   logic [SIG_W-1:0] sig;
   logic             sig_ok;
   logic             sig_clear;

   assign sig_clear = pass_end | dev_start;
   assign sig_ok    = (sig == exp_sig);

   mvl_sym_unpack u_unpack (
      .clk          (clk),
      .rst_n        (rst_n),
      .sym_valid    (sym_valid),
      .sym_in       (sym_in),
      .fields       (fields),
      .fields_valid (test_valid)
   );

   mvl_misr #(.SIG_W(SIG_W), .IN_W(SYM_W), .POLY(POLY)) u_misr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (sig_clear),
      .fold  (sym_valid),
      .din   (sym_in),
      .sig   (sig)
   );

   mvl_retry_ctrl #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_retry (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_start (dev_start),
      .pass_end  (pass_end),
      .sig_ok    (sig_ok),
      .pass      (pass),
      .fail      (fail),
      .retest    (retest)
   );

   assign test_pi = fields.pi;
   assign scan_in = fields.scan_in;
   assign scan_en = fields.scan_en;

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pass, fail, retest})); // R8
   AST_VERDICT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_end && !dev_start) |=> (pass || fail || retest)); // R5
   AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_end && !dev_start) |=> !(pass || fail || retest)); // R8
   AST_MATCH_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_end && !dev_start && sig_ok) |=> pass); // R5
endmodule

// File: tb/mvl_test_rx_bench.sv
module mvl_test_rx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_start = 1'b0;
   logic        sym_valid = 1'b0;
   logic [4:0]  sym_in = '0;
   logic        pass_end = 1'b0;
   logic [15:0] exp_sig = '0;
   logic [2:0]  test_pi;
   logic        scan_in, scan_en, test_valid, pass, fail, retest;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mvl_test_rx u_mvl_test_rx (
      .clk(clk), .rst_n(rst_n), .dev_start(dev_start), .sym_valid(sym_valid),
      .sym_in(sym_in), .pass_end(pass_end), .exp_sig(exp_sig),
      .test_pi(test_pi), .scan_in(scan_in), .scan_en(scan_en),
      .test_valid(test_valid), .pass(pass), .fail(fail), .retest(retest)
   );

   typedef struct {
      logic [4:0] flds;
      logic       tv;
      logic       p;
      logic       f;
      logic       r;
   } exp_t;

   exp_t q[$];

   // bench model state
   logic [15:0] m_sig = '0;
   int          m_tries = 0;
   logic [4:0]  m_hold = '0;

   function automatic logic [15:0] fold(input logic [15:0] s, input logic [4:0] d);
      return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ {11'b0, d};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
      end
   endtask

   task automatic drive(input bit dv, input bit pe, input bit v,
                        input logic [4:0] s, input bit wrong);
      exp_t e;
      int   t;
      @(negedge clk);
      dev_start = dv; pass_end = pe; sym_valid = v; sym_in = s;
      exp_sig   = wrong ? (m_sig ^ 16'h0001) : m_sig;
      e.tv = v; e.p = 0; e.f = 0; e.r = 0;
      if (v) m_hold = s;
      e.flds = m_hold;
      if (dv) begin
         m_tries = 0;
         m_sig = v ? fold(16'h0, s) : 16'h0;
      end else if (pe) begin
         t = (m_tries >= 4) ? 4 : m_tries + 1;
         m_tries = t;
         if (!wrong)      e.p = 1;
         else if (t < 4)  e.r = 1;
         else             e.f = 1;
         m_sig = v ? fold(16'h0, s) : 16'h0;
      end else if (v) begin
         m_sig = fold(m_sig, s);
      end
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 5'd0, 0);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R2 fields", {11'b0, scan_en, scan_in, test_pi}, {11'b0, e.flds});
            chk("R3 test_valid", {15'b0, test_valid}, {15'b0, e.tv});
            chk("R5 pass", {15'b0, pass}, {15'b0, e.p});
            chk("R6 retest", {15'b0, retest}, {15'b0, e.r});
            chk("R7 fail", {15'b0, fail}, {15'b0, e.f});
         end
      end
   end

   initial begin
      #200us;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs held at zero during reset
      chk("R1 reset", {9'b0, test_pi, scan_in, scan_en, test_valid, pass, fail, retest}, 16'h0);
      rst_n = 1'b1;
      @(posedge clk); #2;
      chk("R1 after release", {9'b0, test_pi, scan_in, scan_en, test_valid, pass, fail, retest}, 16'h0);

      // R2 R3 R4 R5: every code, with gaps, then a matching pass
      drive(1, 0, 0, 5'd0, 0);
      for (int k = 0; k < 32; k++) begin
         drive(0, 0, 1, 5'(k), 0);
         if (k % 5 == 2) idle(1);
      end
      drive(0, 1, 0, 5'd0, 0);             // R5 pass
      idle(2);

      // R6 R7 R9: four corrupted passes, then a fifth
      drive(1, 0, 0, 5'd0, 0);
      for (int a = 0; a < 5; a++) begin
         drive(0, 0, 1, 5'h15, 0);
         drive(0, 0, 1, 5'h0A, 0);
         drive(0, 1, 0, 5'd0, 1);          // retest x3, then fail x2
         idle(1);
      end
      // R5 match after limit still passes
      drive(0, 0, 1, 5'h1F, 0);
      drive(0, 1, 0, 5'd0, 0);
      idle(1);

      // R9 R8: dev_start together with pass_end gives no verdict, count reset
      drive(0, 0, 1, 5'h11, 0);
      drive(1, 1, 0, 5'd0, 1);
      drive(0, 0, 1, 5'h03, 0);
      drive(0, 1, 0, 5'd0, 1);             // first attempt: retest
      idle(1);

      // R4: symbol in the same cycle as pass_end starts the next pass
      drive(0, 0, 1, 5'h1C, 0);
      drive(0, 1, 1, 5'h07, 0);            // attempt 2 pass, 0x07 carried
      drive(0, 0, 1, 5'h18, 0);
      drive(0, 1, 0, 5'd0, 0);             // pass only if carry folded
      idle(3);

      // drain the scoreboard
      while (q.size() > 0) @(posedge clk);
      @(posedge clk); #3;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule